// File: doc/BRIEF.md
# Serial Line Transmitter with Reload Prescaler

This block sends one byte at a time on an asynchronous serial line for a 16-bit minicomputer I/O bus. A free-running 16-bit prescaler counts reference clocks. Each time it passes its all-ones value, it loads a 16-bit preset and emits one overflow tick. The preset stands in for a hard-wired divisor, so the divide ratio is 65536 minus the preset.

A transmit command hands the block the low byte of the accumulator. The block waits for the next overflow tick and then drives the frame out of a 12-bit shift register built from three 4-bit sections. The frame is a low start bit, the eight data bits least significant first, and one or two high stop bits. Every line bit is held for two overflow ticks.

When the last stop bit ends, the block sets an output-done flag. Software can test the flag for a skip and clear it with a separate command.

The byte enters on a valid/ready pair. A byte transfers on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is high only while the transmitter is completely idle. A source that sees `tx_ready` low may keep `tx_valid` high until the transfer happens, or it may drop `tx_valid`. A request that is withdrawn before `tx_ready` rises leaves no trace.

Top module: `sertx_top`

## Requirements
- R1: After reset the line `txd` is high, `out_done` is low and `tx_ready` is high. Whenever `tx_ready` is high, the line is high.
- R2: Overflow ticks come exactly every 65536 minus `preset` clocks. When the prescaler passes 16'hFFFF it reloads `preset`.
- R3: A frame on `txd` is one low start bit, then data bits 0 to 7 in that order, then STOP_BITS high stop bits, where STOP_BITS is 1 or 2. The line idles high.
- R4: A byte is taken on a cycle where `tx_valid` and `tx_ready` are both high, and `tx_ready` is low on the next cycle. The start bit begins with the first overflow tick after acceptance. `tx_ready` stays low until the frame ends.
- R5: A `tx_valid` pulse while `tx_ready` is low is ignored. The frame in flight keeps its bits, and no further frame follows it.
- R6: `out_done` rises in the clock after the last stop bit has lasted its full two ticks, and not earlier. Once high, it stays high until cleared.
- R7: A one-cycle `flag_clr` pulse makes `out_done` low from the next clock. If the clear and the end of a frame fall on the same cycle, the flag ends up set.
- R8: Each line bit lasts exactly 2 × (65536 − `preset`) clocks, and `txd` changes only on a clock that follows an overflow tick.
- R9: Starting a new frame leaves `out_done` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the prescaler advances once per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| preset | input | 16 | Prescaler reload value; divisor is 65536 minus this value |
| tx_valid | input | 1 | Transmit command carrying a byte |
| tx_data | input | 8 | Low byte of the accumulator to send |
| tx_ready | output | 1 | High while the transmitter is idle and can accept a byte |
| flag_clr | input | 1 | Clear command for the output-done flag |
| out_done | output | 1 | Output-done flag, for the skip test |
| txd | output | 1 | Serial line, idle high |

## Verification
The bound checker watches the following on every cycle:
- the spacing between overflow ticks against the preset;
- that the line stays still between ticks;
- that the line is high whenever the block is ready;
- that the handshake drops `tx_ready` after acceptance;
- that the flag holds until it is cleared and rises only when the block is idle again.

Only the bench scenarios can show the remaining behaviour:
- the bit order and the level of each bit, sampled at mid-bit;
- the exact clock on which the flag rises;
- that a clear landing on the frame's end loses to the set;
- that a command poked into a running frame changes neither that frame nor what follows it.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_WAIT = 2'd1,
    TX_SEND = 2'd2
  } tx_state_e;

  // number of line bits in one frame: start + data + stop
  function automatic int frame_len(input int data_w, input int stop_bits);
    return 1 + data_w + stop_bits;
  endfunction
endpackage

// File: rtl/sertx_prescaler.sv
module sertx_prescaler #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] preset,
  output logic             tick
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q;

  assign tick = (cnt_q == CNT_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= preset;
    else if (tick) cnt_q <= preset;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int SECT_W = 4,
  parameter int N_SECT = 3,
  localparam int SR_W  = SECT_W * N_SECT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            shift,
  input  logic [SR_W-1:0] load_val,
  output logic            ser_o
);
  logic [N_SECT-1:0] sect_lsb;

  for (genvar g = 0; g < N_SECT; g++) begin : g_sect
    logic [SECT_W-1:0] q;
    logic              fill;
    if (g == N_SECT - 1) begin : g_top
      assign fill = 1'b1;
    end else begin : g_mid
      assign fill = sect_lsb[g+1];
    end
    assign sect_lsb[g] = q[0];
    always_ff @(posedge clk) begin
      if (!rst_n)     q <= '1;
      else if (load)  q <= load_val[g*SECT_W +: SECT_W];
      else if (shift) q <= {fill, q[SECT_W-1:1]};
    end
  end

  assign ser_o = sect_lsb[0];
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STOP_BITS = 1,
  parameter int SR_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              flag_clr,
  output logic              tx_ready,
  output logic              load,
  output logic              shift,
  output logic [SR_W-1:0]   load_val,
  output logic              out_done
);
  localparam int FRAME_W = frame_len(DATA_W, STOP_BITS);
  localparam int BCNT_W  = $clog2(FRAME_W + 1);

  tx_state_e         state_q;
  logic              phase_q;
  logic [BCNT_W-1:0] bits_left_q;
  logic [DATA_W-1:0] data_q;
  logic              frame_end;

  assign tx_ready  = (state_q == TX_IDLE);
  assign load      = (state_q == TX_WAIT) && tick;
  assign shift     = (state_q == TX_SEND) && tick && phase_q;
  assign frame_end = shift && (bits_left_q == BCNT_W'(1));

  always_comb begin
    load_val               = '1;
    load_val[0]            = 1'b0;
    load_val[DATA_W:1]     = data_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= TX_IDLE;
      phase_q     <= 1'b0;
      bits_left_q <= '0;
      data_q      <= '0;
    end else begin
      unique case (state_q)
        TX_IDLE: if (tx_valid) begin
          data_q  <= tx_data;
          state_q <= TX_WAIT;
        end
        TX_WAIT: if (tick) begin
          phase_q     <= 1'b0;
          bits_left_q <= BCNT_W'(FRAME_W);
          state_q     <= TX_SEND;
        end
        TX_SEND: if (tick) begin
          phase_q <= ~phase_q;
          if (phase_q) begin
            bits_left_q <= bits_left_q - 1'b1;
            if (bits_left_q == BCNT_W'(1)) state_q <= TX_IDLE;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  // set has priority over clear
  always_ff @(posedge clk) begin
    if (!rst_n)         out_done <= 1'b0;
    else if (frame_end) out_done <= 1'b1;
    else if (flag_clr)  out_done <= 1'b0;
  end
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int DATA_W    = 8,
  parameter int STOP_BITS = 1,
  parameter int CNT_W     = 16,
  parameter int SECT_W    = 4,
  parameter int N_SECT    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  preset,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              flag_clr,
  output logic              out_done,
  output logic              txd
);
  localparam int SR_W = SECT_W * N_SECT;

  logic            tick;
  logic            load;
  logic            shift;
  logic [SR_W-1:0] load_val;

  sertx_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .preset (preset),
    .tick   (tick)
  );

  sertx_ctrl #(.DATA_W(DATA_W), .STOP_BITS(STOP_BITS), .SR_W(SR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .flag_clr (flag_clr),
    .tx_ready (tx_ready),
    .load     (load),
    .shift    (shift),
    .load_val (load_val),
    .out_done (out_done)
  );

  sertx_shifter #(.SECT_W(SECT_W), .N_SECT(N_SECT)) u_shf (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .shift    (shift),
    .load_val (load_val),
    .ser_o    (txd)
  );
endmodule

// File: rtl/sertx_checker.sv
module sertx_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] preset,
  input logic             tick,
  input logic             txd,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             flag_clr,
  input logic             out_done
);
  logic [CNT_W:0] since_q;
  logic           seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (tick) begin
      since_q <= (CNT_W+1)'(1);
      seen_q  <= 1'b1;
    end else begin
      since_q <= since_q + 1'b1;
    end
  end

  a_r1_ready_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen_q) |-> (since_q == ((CNT_W+1)'(1) << CNT_W) - {1'b0, preset}));

  a_r8_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(txd));

  a_r4_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && !flag_clr) |=> out_done);

  a_r6_flag_rises_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_done) |-> tx_ready);
endmodule

bind sertx_top sertx_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .preset   (preset),
  .tick     (tick),
  .txd      (txd),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .flag_clr (flag_clr),
  .out_done (out_done)
);

// File: tb/sertx_top_test.sv
module sertx_top_test;
  localparam logic [15:0] PRESET = 16'd65530;
  localparam int DIV   = 65536 - 65530;
  localparam int STOPS = 2;
  localparam int NB    = 1 + 8 + STOPS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       flag_clr = 1'b0;
  logic       tx_ready, out_done, txd;

  int  checks = 0;
  int  errors = 0;
  int  cyc = 0;
  bit  model_flag = 1'b0;

  sertx_top #(.STOP_BITS(STOPS)) uut (
    .clk(clk), .rst_n(rst_n), .preset(PRESET),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .flag_clr(flag_clr), .out_done(out_done), .txd(txd)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    model_flag = 1'b0;
    chk(out_done == 1'b0, "R7 clear", out_done, 0);
  endtask

  // Sends one byte and checks every bit at mid-bit.
  task automatic send_frame(input logic [7:0] b, input bit poke, input bit clr_at_end);
    bit expb;
    while (!tx_ready) @(negedge clk);
    tx_data = b; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R4 ready low after accept", tx_ready, 0);
    while (txd) @(negedge clk);
    chk(out_done == model_flag, "R9 flag unchanged by start", out_done, model_flag);
    wait_neg(DIV);
    chk(txd == 1'b0, "R3 start bit", txd, 0);
    for (int k = 1; k < NB; k++) begin
      if (poke && k == 4) begin
        tx_data = ~b; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        wait_neg(2*DIV - 1);
      end else begin
        wait_neg(2*DIV);
      end
      expb = (k <= 8) ? b[k-1] : 1'b1;
      if (poke && k >= 4)
        chk(txd == expb, "R5 frame intact after poke", txd, expb);
      else
        chk(txd == expb, "R3 data/stop bit", txd, expb);
    end
    wait_neg(DIV - 1);
    chk(out_done == model_flag, "R6 flag not early", out_done, model_flag);
    if (clr_at_end) flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    model_flag = 1'b1;
    chk(out_done == 1'b1, clr_at_end ? "R7 set wins over clear" : "R6 flag at end",
        out_done, 1);
    chk(tx_ready == 1'b1, "R4 ready at frame end", tx_ready, 1);
    if (poke) begin
      for (int i = 0; i < 4*DIV; i++) begin
        @(negedge clk);
        if (i % DIV == 0) chk(txd == 1'b1, "R5 no extra frame", txd, 1);
      end
    end
  endtask

  task automatic measure_start();
    int n;
    while (!tx_ready) @(negedge clk);
    tx_data = 8'h01; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    while (txd) @(negedge clk);
    n = 0;
    while (!txd) begin
      @(negedge clk);
      n++;
    end
    chk(n == 2*DIV, "R2 R8 bit length", n, 2*DIV);
    while (!tx_ready) @(negedge clk);
    wait_neg(1);
    model_flag = 1'b1;
    chk(out_done == 1'b1, "R6 flag after measured frame", out_done, 1);
  endtask

  initial begin
    logic [7:0] rb;
    void'($urandom(32'd4711));
    wait_neg(5);
    rst_n = 1'b1;
    wait_neg(1);
    chk(txd == 1'b1, "R1 line idle", txd, 1);
    chk(out_done == 1'b0, "R1 flag clear", out_done, 0);
    chk(tx_ready == 1'b1, "R1 ready", tx_ready, 1);
    wait_neg(3*DIV);
    chk(txd == 1'b1, "R1 idle stays high", txd, 1);

    send_frame(8'h00, 1'b0, 1'b0);
    send_frame(8'hFF, 1'b0, 1'b0);
    clear_flag();
    send_frame(8'h55, 1'b1, 1'b0);
    clear_flag();
    send_frame(8'hA5, 1'b0, 1'b1);
    clear_flag();
    measure_start();
    clear_flag();
    send_frame(8'h80, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) begin
      rb = 8'($urandom);
      if ($urandom % 2 == 0) clear_flag();
      send_frame(rb, ($urandom % 4) == 0, ($urandom % 3) == 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule